// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block gathers level-sensitive interrupt requests and presents them to a processor on one interrupt line. It has a primary bank of 40 sources and a secondary bank of 32 sources. Every source has a pending flag and an enable flag. Software controls these flags through a small word-addressed register window. Enable flags are changed only through paired set and clear words, in which each 1 bit acts on one source. Pending flags are cleared by writing ones. The secondary bank folds into primary source 0: any secondary source that is both enabled and pending raises the request of that primary line.

To find the cause of an interrupt, a handler reads the priority index word. This word gives the lowest-numbered active primary source in the range 1 to 39. A value of zero tells the handler to read the secondary status word instead. A table of 40 channel words is also provided. It is plain read/write storage for mapping values that software maintains.

Reads are combinational from the address. Writes take effect at the clock edge where the write strobe is high. All widths and counts are parameters, and the defaults give the sizes described here.

Top module: `intc_cascade`

## Requirements
- R1: After reset, all pending flags, all enable flags and all channel words are zero, and `cpu_irq` is low.
- R2: A primary pending flag is set at every clock edge where its request is high. Primary pending reads back at 0x00 (sources 0–31, source n in bit n) and at 0x04 (sources 32–39 in bits 7:0). Writing 1 to a bit of 0x10 or 0x14 clears that flag, but only when its request is low at that edge.
- R3: Writing 1 to a bit of 0x20 (sources 0–31) or 0x24 (sources 32–39 in bits 7:0) enables that source. Zero bits change nothing. The primary enable flags read back at 0x20/0x24 and also at 0x30/0x34.
- R4: Writing 1 to a bit of 0x30 or 0x34 disables that source. Zero bits change nothing.
- R5: Bits 31:8 of writes to 0x14, 0x24 and 0x34 are ignored, and reads of 0x04, 0x24 and 0x34 return zero in bits 31:8.
- R6: The secondary bank works like the primary one. Requests set pending. Writing ones to 0x88 clears pending when the request is low. Writing ones to 0x90 enables sources and writing ones to 0x98 disables them. The secondary enable flags read back at 0x90 and 0x98.
- R7: A read of 0x80 returns the secondary flags that are both pending and enabled, with source n in bit n.
- R8: The effective request of primary source 0 is `prim_req[0]` ORed with "any secondary source pending and enabled". A secondary request therefore reaches `cpu_irq` three clock edges after it is first sampled, provided primary source 0 is enabled.
- R9: A read of 0x40 returns, in bits 5:0, the lowest index n in 1–39 whose primary pending and enable flags are both set. It returns 0 if there is no such source. Bits 31:6 read zero.
- R10: `cpu_irq` is a register. After each clock edge it equals the OR of (pending AND enable) over all primary sources as they stood before that edge.
- R11: Channel word c (0–39) at address 0x200 + 4·c holds the last 32-bit value written there and reads it back unchanged.
- R12: Reads of any address not listed above (for example 0x10, 0x44, 0x84, 0x2A0, or an unaligned address) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| prim_req | input | 40 | Primary level requests, bit n for source n |
| sec_req | input | 32 | Secondary level requests |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to reach from the ports is a clear that races a live request. A clear write arrives while the request is still high, so the flag must survive. The stimulus then has to drop the request and clear again in a later cycle. A second hard case is the secondary path. A secondary request has to pass through two flag stages before `cpu_irq` rises, and it must leave the priority index at 0 throughout. Directed sequences step through both cases edge by edge. A long random phase then mixes sparse request patterns, set/clear writes with random masks (including upper bits that must be ignored), channel writes and reads of every decoded and several undecoded addresses. All of this is checked against a cycle model kept in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // register window offsets (bytes)
   localparam int unsigned OFF_PEND   = 'h000;   // primary raw pending, read
   localparam int unsigned OFF_PCLR   = 'h010;   // primary pending clear, write ones
   localparam int unsigned OFF_ESET   = 'h020;   // primary enable set
   localparam int unsigned OFF_ECLR   = 'h030;   // primary enable clear
   localparam int unsigned OFF_PRIO   = 'h040;   // priority index, read
   localparam int unsigned OFF_SSTAT  = 'h080;   // secondary active status
   localparam int unsigned OFF_SCLR   = 'h088;   // secondary pending clear
   localparam int unsigned OFF_SESET  = 'h090;   // secondary enable set
   localparam int unsigned OFF_SECLR  = 'h098;   // secondary enable clear
   localparam int unsigned OFF_MAP    = 'h200;   // channel table base
   localparam int unsigned WORD_BYTES = 4;

   function automatic int unsigned words_for(input int unsigned n, input int unsigned w);
      return (n + w - 1) / w;
   endfunction

endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
   parameter int unsigned NSRC = 40,
   parameter int unsigned DW   = 32,
   localparam int unsigned NWORD = (NSRC + DW - 1) / DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  req,
   input  logic [NWORD-1:0] sel_pclr,
   input  logic [NWORD-1:0] sel_eset,
   input  logic [NWORD-1:0] sel_eclr,
   input  logic [DW-1:0]    wdata,
   output logic [NSRC-1:0]  pend,
   output logic [NSRC-1:0]  en
);

   logic [NSRC-1:0] pclr_m;
   logic [NSRC-1:0] eset_m;
   logic [NSRC-1:0] eclr_m;

   // spread each word strobe over the sources it covers
   for (genvar i = 0; i < NSRC; i++) begin : g_mask
      localparam int unsigned WI = i / DW;
      localparam int unsigned BI = i % DW;
      assign pclr_m[i] = sel_pclr[WI] & wdata[BI];
      assign eset_m[i] = sel_eset[WI] & wdata[BI];
      assign eclr_m[i] = sel_eclr[WI] & wdata[BI];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         en   <= '0;
      end else begin
         // a live level request wins over a clear
         pend <= req | (pend & ~pclr_m);
         en   <= (en | eset_m) & ~eclr_m;
      end
   end

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
   parameter int unsigned NSRC  = 40,
   parameter int unsigned FIRST = 1,
   localparam int unsigned IW   = $clog2(NSRC)
) (
   input  logic [NSRC-1:0] act,
   output logic [IW-1:0]   idx
);

   // scan downward so the lowest active index is the last one assigned
   always_comb begin
      idx = '0;
      for (int i = NSRC - 1; i >= int'(FIRST); i--) begin
         if (act[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/intc_chmap.sv
module intc_chmap #(
   parameter int unsigned NCH = 40,
   parameter int unsigned DW  = 32,
   localparam int unsigned IW = $clog2(NCH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [IW-1:0] sel,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            mem[c] <= '0;
         else if (wr && (sel == IW'(c)))        mem[c] <= wdata;
      end
   end

   assign rdata = mem[sel];

endmodule

// File: rtl/intc_cascade.sv
module intc_cascade #(
   parameter int unsigned NUM_PRI = 40,
   parameter int unsigned NUM_SEC = 32,
   parameter int unsigned NUM_CH  = 40,
   parameter int unsigned DW      = 32,
   parameter int unsigned ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   input  logic [NUM_PRI-1:0] prim_req,
   input  logic [NUM_SEC-1:0] sec_req,
   output logic               cpu_irq
);
   import intc_pkg::*;

   localparam int unsigned PW   = words_for(NUM_PRI, DW);
   localparam int unsigned PADW = PW * DW;
   localparam int unsigned IW   = $clog2(NUM_PRI);
   localparam int unsigned CIW  = $clog2(NUM_CH);

   // elaboration-time parameter checks
   if (NUM_SEC > DW) begin : g_bad_sec
      $error("intc_cascade: NUM_SEC must fit one data word");
   end
   if (NUM_PRI < 2 || IW > DW) begin : g_bad_pri
      $error("intc_cascade: NUM_PRI out of range");
   end
   if (OFF_MAP + WORD_BYTES * NUM_CH > (1 << ADDR_W)) begin : g_bad_map
      $error("intc_cascade: channel table exceeds address space");
   end
   if (OFF_ESET - OFF_PCLR < WORD_BYTES * PW) begin : g_bad_bank
      $error("intc_cascade: too many primary words for the register stride");
   end

   // ---------------- write decode ----------------
   logic [PW-1:0] p_sel_pclr, p_sel_eset, p_sel_eclr;
   for (genvar w = 0; w < PW; w++) begin : g_pdec
      assign p_sel_pclr[w] = bus_wr && (bus_addr == ADDR_W'(OFF_PCLR + WORD_BYTES * w));
      assign p_sel_eset[w] = bus_wr && (bus_addr == ADDR_W'(OFF_ESET + WORD_BYTES * w));
      assign p_sel_eclr[w] = bus_wr && (bus_addr == ADDR_W'(OFF_ECLR + WORD_BYTES * w));
   end

   logic [0:0] s_sel_pclr, s_sel_eset, s_sel_eclr;
   assign s_sel_pclr[0] = bus_wr && (bus_addr == ADDR_W'(OFF_SCLR));
   assign s_sel_eset[0] = bus_wr && (bus_addr == ADDR_W'(OFF_SESET));
   assign s_sel_eclr[0] = bus_wr && (bus_addr == ADDR_W'(OFF_SECLR));

   // channel table hit
   logic           map_hit;
   logic [CIW-1:0] map_sel;
   always_comb begin
      map_hit = 1'b0;
      map_sel = '0;
      for (int c = 0; c < int'(NUM_CH); c++) begin
         if (bus_addr == ADDR_W'(OFF_MAP + WORD_BYTES * c)) begin
            map_hit = 1'b1;
            map_sel = CIW'(c);
         end
      end
   end

   // ---------------- secondary bank ----------------
   logic [NUM_SEC-1:0] sec_pend, sec_en;

   intc_bank #(.NSRC(NUM_SEC), .DW(DW)) u_sec (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (sec_req),
      .sel_pclr (s_sel_pclr),
      .sel_eset (s_sel_eset),
      .sel_eclr (s_sel_eclr),
      .wdata    (bus_wdata),
      .pend     (sec_pend),
      .en       (sec_en)
   );

   logic [NUM_SEC-1:0] sec_act;
   logic               casc_req;
   assign sec_act  = sec_pend & sec_en;
   assign casc_req = |sec_act;

   // ---------------- primary bank ----------------
   logic [NUM_PRI-1:0] pri_req_eff, pri_pend, pri_en, pri_act;
   assign pri_req_eff = prim_req | NUM_PRI'(casc_req);

   intc_bank #(.NSRC(NUM_PRI), .DW(DW)) u_pri (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (pri_req_eff),
      .sel_pclr (p_sel_pclr),
      .sel_eset (p_sel_eset),
      .sel_eclr (p_sel_eclr),
      .wdata    (bus_wdata),
      .pend     (pri_pend),
      .en       (pri_en)
   );

   assign pri_act = pri_pend & pri_en;

   logic [IW-1:0] prio_idx;
   intc_prio #(.NSRC(NUM_PRI), .FIRST(1)) u_prio (
      .act (pri_act),
      .idx (prio_idx)
   );

   // ---------------- channel table ----------------
   logic [DW-1:0] map_rdata;
   intc_chmap #(.NCH(NUM_CH), .DW(DW)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr && map_hit),
      .sel   (map_sel),
      .wdata (bus_wdata),
      .rdata (map_rdata)
   );

   // ---------------- interrupt output ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpu_irq <= 1'b0;
      else        cpu_irq <= |pri_act;
   end

   // ---------------- read mux ----------------
   logic [PADW-1:0] pend_pad, en_pad;
   assign pend_pad = PADW'(pri_pend);
   assign en_pad   = PADW'(pri_en);

   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < int'(PW); w++) begin
         if (bus_addr == ADDR_W'(OFF_PEND + WORD_BYTES * w))
            bus_rdata = pend_pad[w*DW +: DW];
         if (bus_addr == ADDR_W'(OFF_ESET + WORD_BYTES * w) ||
             bus_addr == ADDR_W'(OFF_ECLR + WORD_BYTES * w))
            bus_rdata = en_pad[w*DW +: DW];
      end
      if (bus_addr == ADDR_W'(OFF_PRIO))  bus_rdata = DW'(prio_idx);
      if (bus_addr == ADDR_W'(OFF_SSTAT)) bus_rdata = DW'(sec_act);
      if (bus_addr == ADDR_W'(OFF_SESET) || bus_addr == ADDR_W'(OFF_SECLR))
         bus_rdata = DW'(sec_en);
      if (map_hit) bus_rdata = map_rdata;
   end

endmodule

// File: rtl/intc_cascade_chk.sv
module intc_cascade_chk #(
   parameter int unsigned NUM_PRI = 40,
   parameter int unsigned NUM_SEC = 32,
   parameter int unsigned DW      = 32,
   parameter int unsigned ADDR_W  = 12,
   localparam int unsigned IW     = $clog2(NUM_PRI)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr,
   input logic [DW-1:0]      bus_wdata,
   input logic [NUM_PRI-1:0] prim_req,
   input logic               cpu_irq,
   input logic [NUM_PRI-1:0] pri_pend,
   input logic [NUM_PRI-1:0] pri_en,
   input logic [NUM_SEC-1:0] sec_pend,
   input logic [NUM_SEC-1:0] sec_en,
   input logic [IW-1:0]      prio_idx
);
   import intc_pkg::*;

   // R10: output is last cycle's OR of active primary sources
   p_irq_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cpu_irq == $past(|(pri_pend & pri_en))));

   // R2: a sampled request leaves its pending flag set
   p_req_sets_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pri_pend & $past(prim_req)) == $past(prim_req)));

   // R3: enable-set bits are set afterwards (low word)
   p_enable_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_ESET)) |=>
         ((pri_en[DW-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

   // R4: enable-clear bits are clear afterwards (low word)
   p_enable_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_ECLR)) |=>
         ((pri_en[DW-1:0] & $past(bus_wdata)) == '0));

   // R6: secondary enable-set
   p_sec_enable_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_SESET)) |=>
         ((sec_en & $past(bus_wdata[NUM_SEC-1:0])) == $past(bus_wdata[NUM_SEC-1:0])));

   // R8: an active secondary source raises primary source 0
   p_cascade_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sec_pend & sec_en)) |=> pri_pend[0]);

   // R9: no active source in 1..top gives index zero
   p_prio_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (((pri_pend & pri_en) >> 1) == '0) |-> (prio_idx == '0));

   // R9: a nonzero index names an active source with none below it
   p_prio_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_idx != '0) |-> (pri_pend[prio_idx] && pri_en[prio_idx] &&
         (((pri_pend & pri_en) & ((NUM_PRI'(1) << prio_idx) - NUM_PRI'(1)) &
           ~NUM_PRI'(1)) == '0)));

endmodule

bind intc_cascade intc_cascade_chk #(
   .NUM_PRI (NUM_PRI),
   .NUM_SEC (NUM_SEC),
   .DW      (DW),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .prim_req  (prim_req),
   .cpu_irq   (cpu_irq),
   .pri_pend  (pri_pend),
   .pri_en    (pri_en),
   .sec_pend  (sec_pend),
   .sec_en    (sec_en),
   .prio_idx  (prio_idx)
);

// File: tb/intc_cascade_bench.sv
module intc_cascade_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [39:0] prim_req = '0;
   logic [31:0] sec_req = '0;
   logic        cpu_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   intc_cascade u_intc_cascade (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .prim_req  (prim_req),
      .sec_req   (sec_req),
      .cpu_irq   (cpu_irq)
   );

   // ---------------- bench cycle model ----------------
   logic [39:0] m_pend, m_en;
   logic [31:0] m_spend, m_sen;
   logic        m_irq;
   logic [31:0] m_map [40];

   always @(posedge clk or negedge rst_n) begin : model
      logic [39:0] pc, es, ec, re;
      logic [31:0] spc, ses, sc;
      if (!rst_n) begin
         m_pend <= '0; m_en <= '0; m_spend <= '0; m_sen <= '0; m_irq <= 1'b0;
         for (int c = 0; c < 40; c++) m_map[c] <= '0;
      end else begin
         pc = '0; es = '0; ec = '0; spc = '0; ses = '0; sc = '0;
         if (bus_wr) begin
            case (bus_addr)
               12'h010: pc[31:0]  = bus_wdata;
               12'h014: pc[39:32] = bus_wdata[7:0];
               12'h020: es[31:0]  = bus_wdata;
               12'h024: es[39:32] = bus_wdata[7:0];
               12'h030: ec[31:0]  = bus_wdata;
               12'h034: ec[39:32] = bus_wdata[7:0];
               12'h088: spc = bus_wdata;
               12'h090: ses = bus_wdata;
               12'h098: sc  = bus_wdata;
               default: ;
            endcase
            if (bus_addr >= 12'h200 && bus_addr <= 12'h29C && bus_addr[1:0] == 2'b00)
               m_map[(bus_addr - 12'h200) >> 2] <= bus_wdata;
         end
         re = prim_req;
         re[0] = re[0] | (|(m_spend & m_sen));
         m_irq   <= |(m_pend & m_en);
         m_pend  <= re | (m_pend & ~pc);
         m_en    <= (m_en | es) & ~ec;
         m_spend <= sec_req | (m_spend & ~spc);
         m_sen   <= (m_sen | ses) & ~sc;
      end
   end

   function automatic logic [31:0] exp_prio();
      for (int i = 1; i < 40; i++)
         if (m_pend[i] && m_en[i]) return 32'(i);
      return 32'd0;
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a)
         12'h000:          return m_pend[31:0];
         12'h004:          return {24'b0, m_pend[39:32]};
         12'h020, 12'h030: return m_en[31:0];
         12'h024, 12'h034: return {24'b0, m_en[39:32]};
         12'h040:          return exp_prio();
         12'h080:          return m_spend & m_sen;
         12'h090, 12'h098: return m_sen;
         default: begin
            if (a >= 12'h200 && a <= 12'h29C && a[1:0] == 2'b00)
               return m_map[(a - 12'h200) >> 2];
            return 32'd0;
         end
      endcase
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // one bus write; returns at the next falling edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_model(input logic [11:0] a, input string req);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp_read(a));
   endtask

   task automatic rd_lit(input logic [11:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic [11:0] pick_addr(input int unsigned r);
      case (r % 18)
         0: return 12'h000;  1: return 12'h004;  2: return 12'h010;  3: return 12'h014;
         4: return 12'h020;  5: return 12'h024;  6: return 12'h030;  7: return 12'h034;
         8: return 12'h040;  9: return 12'h080; 10: return 12'h088; 11: return 12'h090;
        12: return 12'h098; 13: return 12'h044; 14: return 12'h2A0; 15: return 12'h021;
        default: return 12'h200 + 12'(4 * ($urandom % 40));
      endcase
   endfunction

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 irq", {31'b0, cpu_irq}, 32'd0);
      rst_n = 1'b1;
      tick();
      rd_lit(12'h000, 32'd0, "R1 pend");
      rd_lit(12'h020, 32'd0, "R1 en");
      rd_lit(12'h090, 32'd0, "R1 sec en");
      rd_lit(12'h204, 32'd0, "R1 map");
      rd_lit(12'h040, 32'd0, "R1 prio");

      // R3/R5: enable set, upper bits of word 1 ignored
      wr(12'h024, 32'hFFFF_FF00 | 32'h0000_0081);
      rd_lit(12'h024, 32'h0000_0081, "R5 en word1");
      rd_lit(12'h034, 32'h0000_0081, "R3 en alias");
      wr(12'h020, 32'h0000_0021);
      rd_lit(12'h020, 32'h0000_0021, "R3 en set");
      wr(12'h020, 32'h0000_0000);
      rd_lit(12'h020, 32'h0000_0021, "R3 zero no effect");
      // R4
      wr(12'h034, 32'hFFFF_FF01);
      rd_lit(12'h024, 32'h0000_0080, "R4 en clear");

      // R9: sources 5 and 39 active (39 enabled via bit 7 of word 1)
      prim_req[5] = 1'b1; prim_req[39] = 1'b1;
      tick();
      prim_req = '0;
      rd_lit(12'h040, 32'd5, "R9 lowest wins");
      rd_lit(12'h004, 32'h0000_0080, "R2 pend word1");
      chk("R10 irq", {31'b0, cpu_irq}, 32'd0);
      tick();
      chk("R10 irq rise", {31'b0, cpu_irq}, 32'd1);
      // R2: clear source 5 while its request is high -> survives
      prim_req[5] = 1'b1;
      wr(12'h010, 32'h0000_0020);
      rd_lit(12'h000, 32'h0000_0020, "R2 clear blocked");
      prim_req = '0;
      wr(12'h010, 32'h0000_0020);
      rd_lit(12'h000, 32'h0000_0000, "R2 clear");
      rd_lit(12'h040, 32'd39, "R9 top source");
      wr(12'h014, 32'h0000_0080);
      rd_lit(12'h040, 32'd0, "R9 none");
      tick();
      chk("R10 irq fall", {31'b0, cpu_irq}, 32'd0);

      // R8/R7: cascade path timing
      wr(12'h020, 32'h0000_0001);
      wr(12'h090, 32'h0000_0008);
      sec_req[3] = 1'b1;
      tick();                         // edge 1: secondary pending
      sec_req = '0;
      rd_lit(12'h080, 32'h0000_0008, "R7 status");
      chk("R8 irq edge1", {31'b0, cpu_irq}, 32'd0);
      tick();                         // edge 2: primary 0 pending
      rd_lit(12'h000, 32'h0000_0001, "R8 line0");
      chk("R8 irq edge2", {31'b0, cpu_irq}, 32'd0);
      tick();                         // edge 3: output
      chk("R8 irq edge3", {31'b0, cpu_irq}, 32'd1);
      rd_lit(12'h040, 32'd0, "R9 cascade index 0");
      // R6: secondary disable hides status, then clear pending
      wr(12'h098, 32'h0000_0008);
      rd_lit(12'h080, 32'd0, "R6 sec disabled");
      rd_lit(12'h098, 32'd0, "R6 sec en read");
      wr(12'h088, 32'h0000_0008);
      wr(12'h090, 32'h0000_0008);
      rd_lit(12'h080, 32'd0, "R6 sec cleared");

      // R11/R12
      wr(12'h29C, 32'hCAFE_F00D);
      wr(12'h200, 32'h1234_5678);
      rd_lit(12'h29C, 32'hCAFE_F00D, "R11 map last");
      rd_lit(12'h200, 32'h1234_5678, "R11 map first");
      rd_lit(12'h2A0, 32'd0, "R12 past table");
      rd_lit(12'h010, 32'd0, "R12 clear reg");
      rd_lit(12'h044, 32'd0, "R12 gap");
      rd_lit(12'h201, 32'd0, "R12 unaligned");

      // random phase: model comparison
      for (int k = 0; k < 4000; k++) begin
         logic [11:0] a;
         prim_req = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
         sec_req  = $urandom & $urandom & $urandom & $urandom;
         a = pick_addr($urandom);
         chk("R10 irq random", {31'b0, cpu_irq}, {31'b0, m_irq});
         if ($urandom % 2 == 0) begin
            bus_wr = 1'b1; bus_addr = a; bus_wdata = $urandom;
            tick();
            bus_wr = 1'b0;
         end else begin
            rd_model(a, "R2 R3 R4 R6 R7 R9 R11 R12 random read");
            tick();
         end
      end
      prim_req = '0; sec_req = '0;
      tick();
      rd_model(12'h000, "R2 final pend");
      rd_model(12'h080, "R7 final status");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule